// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block turns a segment value and an offset into a linear address. It works in one of two modes. In real mode it shifts the segment left by four bits, adds a 16-bit offset, and passes bit 20 of the sum only while the A20 gate is open. In protected mode the segment input is a selector. The selector picks an 8-byte descriptor from a small table stored inside the block. The descriptor base is added to a full 32-bit offset, and the offset is checked against the descriptor limit. Null selectors, local-table selectors, indices outside the table and offsets beyond the limit each produce a distinct fault cause.

One write port loads three things. The first is the control bits, which are the protected-mode enable and the A20 gate. The second is the table register, which holds the table base and the table size minus one. The third is descriptor entries, addressed by linear byte address relative to the table base. A translation presented in one cycle appears on the outputs after the next rising clock edge. Out of reset the outputs show the first fetch address, formed from the reset code segment 0xF000 and the reset offset 0xFFF0.

Top module: `segxlat`

## Requirements
- R1: While reset is asserted and until the first clock edge after release, `lin_addr` reads 0x000FFFF0 and `fault` reads 0. Out of reset, protected mode is off and the A20 gate is closed.
- R2: With protected mode off, the linear address registered at the next clock edge is segment×16 + `off_in[15:0]`, zero-extended to 32 bits. In this mode `off_in[31:16]` is ignored and `fault` stays 0.
- R3: In real mode with the A20 gate closed, bit 20 of the sum reads 0, so segment 0xFFFF with offset 0xFFFF gives 0x0FFEF and 0xFFFF:0x0010 gives 0x00000. With the gate open, bit 20 passes, so 0xFFFF:0xFFFF gives 0x10FFEF. In protected mode the gate has no effect.
- R4: A write with `wr_kind`=0 loads the control bits: `wr_data[0]` is the protected-mode enable and `wr_data[1]` is the A20 gate. The change takes effect from the following translation. A `wr_kind` of 3 changes nothing.
- R5: A write with `wr_kind`=1 loads the table size minus one from `wr_data[15:0]` and the table base from `wr_data[47:16]`. A write with `wr_kind`=2 stores `wr_data` into slot (`wr_addr` − base)/8, ignoring the low three address bits. If that slot is not below NUM_ENTRIES, the write changes no entry.
- R6: A selector carries the table index in bits [15:3] and the table-select bit in bit 2 (0 selects the global table). Bits [1:0] hold the requested privilege level and do not affect translation.
- R7: A descriptor is laid out as follows: limit[15:0] in bits [15:0], base[23:0] in bits [39:16], limit[19:16] in bits [51:48], granularity in bit 55 and base[31:24] in bits [63:56].
- R8: In protected mode, when no fault occurs, the linear address is the descriptor base plus `off_in`.
- R9: In protected mode a selector with index 0 and table-select 0 faults with cause 1 (null), whatever its privilege bits are.
- R10: In protected mode a selector with table-select 1 faults with cause 2 (local table unsupported).
- R11: In protected mode, if index×8+7 exceeds the table size field, or the index is not below NUM_ENTRIES, the translation faults with cause 3 (outside table).
- R12: The effective limit is the 20-bit limit when granularity is 0, and limit×4096+0xFFF when it is 1. An offset above the effective limit faults with cause 4. An offset equal to the limit does not fault.
- R13: Fault causes are checked in the order null, local table, outside table, limit. On any fault, `fault` reads 1 and `lin_addr` reads 0. Without a fault, `fault_cause` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_kind | input | 2 | Write target: 0 control, 1 table register, 2 descriptor, 3 none |
| wr_addr | input | 32 | Linear byte address of a descriptor write |
| wr_data | input | 64 | Write data |
| seg_in | input | 16 | Segment value (real mode) or selector (protected mode) |
| off_in | input | 32 | Offset |
| lin_addr | output | 32 | Registered linear address |
| fault | output | 1 | Registered fault flag |
| fault_cause | output | 3 | Registered fault cause: 0 none, 1 null, 2 local table, 3 outside table, 4 limit |

## Verification
The bench builds the block with NUM_ENTRIES=4 and the default reset segment and offset. Four slots are enough to reach two separate cases. In the first, the size field already excludes an index, with a three-entry size of 0x17. In the second, the size field admits index 4 (size 0x27) but storage does not hold it. A table base of 0x1000, later moved to 0x2000, shows that the wrapped slot of an address just below the base does not touch slot 3. The same base shows that the low address bits are ignored within a slot.

// File: rtl/segxlat_pkg.sv
package segxlat_pkg;

    localparam int ADDR_W = 32;
    localparam int SEL_W  = 16;
    localparam int IDX_W  = 13;
    localparam int DESC_W = 64;
    localparam int SIZE_W = 16;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_NULL  = 3'd1,
        FLT_LDT   = 3'd2,
        FLT_RANGE = 3'd3,
        FLT_LIMIT = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        WR_CTRL  = 2'd0,
        WR_TABLE = 2'd1,
        WR_DESC  = 2'd2,
        WR_NONE  = 2'd3
    } wr_kind_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic [19:0]       limit;
        logic              gran;
        logic [7:0]        access;
        logic [2:0]        flags_lo;
    } desc_t;

    typedef struct packed {
        logic              pe;
        logic              a20;
        logic [ADDR_W-1:0] tbl_base;
        logic [SIZE_W-1:0] tbl_size;
    } ctrl_t;

    typedef struct packed {
        logic [ADDR_W-1:0] lin;
        fault_e            cause;
    } xlat_t;

    // Field positions of a stored 8-byte descriptor
    function automatic desc_t unpack_desc(input logic [DESC_W-1:0] raw);
        desc_t d;
        d.base     = {raw[63:56], raw[39:16]};
        d.limit    = {raw[51:48], raw[15:0]};
        d.gran     = raw[55];
        d.access   = raw[47:40];
        d.flags_lo = raw[54:52];
        return d;
    endfunction

endpackage

// File: rtl/segxlat_regs.sv
module segxlat_regs
    import segxlat_pkg::*;
#(
    parameter int NUM_ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_kind,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DESC_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_index,
    output logic              pe,
    output logic              a20,
    output logic [SIZE_W-1:0] tbl_size,
    output logic [DESC_W-1:0] rd_raw,
    output logic              rd_hit
);

    localparam int SLOT_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

    ctrl_t ctrl_d, ctrl_q;
    logic [ADDR_W-1:0] wr_off;
    logic [DESC_W-1:0] ent_view [NUM_ENTRIES];

    assign wr_off = wr_addr - ctrl_q.tbl_base;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            case (wr_kind)
                WR_CTRL: begin
                    ctrl_d.pe  = wr_data[0];
                    ctrl_d.a20 = wr_data[1];
                end
                WR_TABLE: begin
                    ctrl_d.tbl_size = wr_data[15:0];
                    ctrl_d.tbl_base = wr_data[47:16];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    // One storage slot per entry; a slot covers eight consecutive bytes
    for (genvar gi = 0; gi < NUM_ENTRIES; gi++) begin : g_ent
        logic [DESC_W-1:0] ent_d, ent_q;
        logic              slot_hit;

        assign slot_hit = (wr_off >= ADDR_W'(gi * 8)) && (wr_off <= ADDR_W'(gi * 8 + 7));

        always_comb begin
            ent_d = ent_q;
            if (wr_en && (wr_kind == WR_DESC) && slot_hit) begin
                ent_d = wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q <= '0;
            end else begin
                ent_q <= ent_d;
            end
        end

        assign ent_view[gi] = ent_q;
    end

    always_comb begin
        rd_hit = (32'(rd_index) < NUM_ENTRIES);
        rd_raw = '0;
        if (rd_hit) begin
            rd_raw = ent_view[rd_index[SLOT_W-1:0]];
        end
    end

    assign pe       = ctrl_q.pe;
    assign a20      = ctrl_q.a20;
    assign tbl_size = ctrl_q.tbl_size;

    // R4: a control write sets both mode bits for the next cycle
    a_r4_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == WR_CTRL) |=> (pe == $past(wr_data[0]) && a20 == $past(wr_data[1])));

    // R5: a table-register write sets the size field
    a_r5_tbl_load: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_kind == WR_TABLE) |=> (tbl_size == $past(wr_data[15:0])));

    // R4: no write means the mode bits hold
    a_r4_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pe) && $stable(a20)));

endmodule

// File: rtl/segxlat_real.sv
module segxlat_real
    import segxlat_pkg::*;
(
    input  logic [SEL_W-1:0]  seg,
    input  logic [15:0]       off,
    input  logic              a20,
    output logic [ADDR_W-1:0] lin
);

    logic [20:0] sum;

    always_comb begin
        sum = {1'b0, seg, 4'b0000} + {5'b0, off};
        lin = '0;
        lin[19:0] = sum[19:0];
        lin[20]   = sum[20] & a20;
    end

endmodule

// File: rtl/segxlat_prot.sv
module segxlat_prot
    import segxlat_pkg::*;
(
    input  logic [SEL_W-3:0]  sel_hi,
    input  logic [ADDR_W-1:0] off,
    input  logic [SIZE_W-1:0] tbl_size,
    input  logic [DESC_W-1:0] raw,
    input  logic              hit,
    output logic [IDX_W-1:0]  rd_index,
    output logic [ADDR_W-1:0] lin,
    output fault_e            cause
);

    logic [IDX_W-1:0]  idx;
    logic              ti;
    desc_t             d;
    logic [ADDR_W-1:0] eff_limit;
    logic              unused_desc;

    assign idx      = sel_hi[SEL_W-3:1];
    assign ti       = sel_hi[0];
    assign rd_index = idx;
    assign d        = unpack_desc(raw);
    assign unused_desc = ^{d.access, d.flags_lo};

    always_comb begin
        eff_limit = d.gran ? {d.limit, 12'hFFF} : {12'h000, d.limit};
        lin = d.base + off;
        if (idx == '0 && !ti) begin
            cause = FLT_NULL;
        end else if (ti) begin
            cause = FLT_LDT;
        end else if (({idx, 3'b111} > tbl_size) || !hit) begin
            cause = FLT_RANGE;
        end else if (off > eff_limit) begin
            cause = FLT_LIMIT;
        end else begin
            cause = FLT_NONE;
        end
    end

endmodule

// File: rtl/segxlat.sv
module segxlat
    import segxlat_pkg::*;
#(
    parameter int          NUM_ENTRIES = 4,
    parameter logic [15:0] RST_SEG     = 16'hF000,
    parameter logic [15:0] RST_OFF     = 16'hFFF0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  wr_kind,
    input  logic [31:0] wr_addr,
    input  logic [63:0] wr_data,
    input  logic [15:0] seg_in,
    input  logic [31:0] off_in,
    output logic [31:0] lin_addr,
    output logic        fault,
    output logic [2:0]  fault_cause
);

    localparam logic [ADDR_W-1:0] RST_LIN =
        ({16'h0000, RST_SEG} << 4) + {16'h0000, RST_OFF};

    logic              pe, a20, rd_hit;
    logic [SIZE_W-1:0] tbl_size;
    logic [DESC_W-1:0] rd_raw;
    logic [IDX_W-1:0]  rd_index;
    logic [ADDR_W-1:0] real_lin, prot_lin;
    fault_e            prot_cause;
    xlat_t             out_d, out_q;

    segxlat_regs #(.NUM_ENTRIES(NUM_ENTRIES)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_kind  (wr_kind),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_index (rd_index),
        .pe       (pe),
        .a20      (a20),
        .tbl_size (tbl_size),
        .rd_raw   (rd_raw),
        .rd_hit   (rd_hit)
    );

    segxlat_real u_real (
        .seg (seg_in),
        .off (off_in[15:0]),
        .a20 (a20),
        .lin (real_lin)
    );

    segxlat_prot u_prot (
        .sel_hi   (seg_in[15:2]),
        .off      (off_in),
        .tbl_size (tbl_size),
        .raw      (rd_raw),
        .hit      (rd_hit),
        .rd_index (rd_index),
        .lin      (prot_lin),
        .cause    (prot_cause)
    );

    always_comb begin
        out_d = out_q;
        if (!pe) begin
            out_d.lin   = real_lin;
            out_d.cause = FLT_NONE;
        end else begin
            out_d.cause = prot_cause;
            out_d.lin   = (prot_cause == FLT_NONE) ? prot_lin : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.lin   <= RST_LIN;
            out_q.cause <= FLT_NONE;
        end else begin
            out_q <= out_d;
        end
    end

    assign lin_addr    = out_q.lin;
    assign fault_cause = out_q.cause;
    assign fault       = (out_q.cause != FLT_NONE);

    // R2: real mode never reports a fault
    a_r2_real_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !pe |=> !fault);

    // R3: closed gate in real mode keeps bit 20 and above at zero
    a_r3_a20_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (!pe && !a20) |=> (lin_addr[31:20] == 12'h000));

    // R9: null selector in protected mode
    a_r9_null_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (pe && seg_in[15:2] == 14'h0) |=> (fault_cause == FLT_NULL));

    // R10: table-select 1 always faults as local table
    a_r10_ldt_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (pe && seg_in[2] && seg_in[15:3] != 13'h0) |=> (fault_cause == FLT_LDT));

    // R13: a reported fault carries a zero address
    a_r13_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (lin_addr == 32'h0));

endmodule

// File: tb/segxlat_tb.sv
module segxlat_tb;

    localparam int CLK_NS = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_kind = 2'd3;
    logic [31:0] wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic [15:0] seg_in = '0;
    logic [31:0] off_in = '0;
    logic [31:0] lin_addr;
    logic        fault;
    logic [2:0]  fault_cause;

    int checks = 0;
    int errors = 0;

    always #(CLK_NS / 2) clk = ~clk;

    segxlat #(.NUM_ENTRIES(4)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_kind     (wr_kind),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .seg_in      (seg_in),
        .off_in      (off_in),
        .lin_addr    (lin_addr),
        .fault       (fault),
        .fault_cause (fault_cause)
    );

    typedef struct packed {
        logic        pe;
        logic        a20;
        logic [15:0] seg;
        logic [31:0] off;
        logic [31:0] lin;
        logic [2:0]  cause;
        logic [7:0]  req;
    } vec_t;

    // Table: base 0x1000, size 0x17 (three entries)
    localparam vec_t VECS [16] = '{
        '{1'b0, 1'b0, 16'hF000, 32'h0000_FFF0, 32'h000F_FFF0, 3'd0, 8'd2},  // R2
        '{1'b0, 1'b0, 16'h1234, 32'h0000_0005, 32'h0001_2345, 3'd0, 8'd2},  // R2
        '{1'b0, 1'b0, 16'h0000, 32'hABCD_0010, 32'h0000_0010, 3'd0, 8'd2},  // R2 high offset ignored
        '{1'b0, 1'b0, 16'hFFFF, 32'h0000_FFFF, 32'h0000_FFEF, 3'd0, 8'd3},  // R3 closed
        '{1'b0, 1'b1, 16'hFFFF, 32'h0000_FFFF, 32'h0010_FFEF, 3'd0, 8'd3},  // R3 open
        '{1'b0, 1'b0, 16'hFFFF, 32'h0000_0010, 32'h0000_0000, 3'd0, 8'd3},  // R3 wrap
        '{1'b1, 1'b0, 16'h0008, 32'h0000_0100, 32'h0000_0100, 3'd0, 8'd8},  // R8
        '{1'b1, 1'b0, 16'h000B, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd0, 8'd12}, // R12 G=1, R6 RPL
        '{1'b1, 1'b0, 16'h0010, 32'h0000_0010, 32'h1234_5688, 3'd0, 8'd7},  // R7, R3 no mask
        '{1'b1, 1'b0, 16'h0010, 32'h0000_0FFF, 32'h1234_6677, 3'd0, 8'd12}, // R12 equal
        '{1'b1, 1'b1, 16'h0010, 32'h0000_1000, 32'h0000_0000, 3'd4, 8'd12}, // R12 over
        '{1'b1, 1'b0, 16'h0000, 32'h0000_0000, 32'h0000_0000, 3'd1, 8'd9},  // R9
        '{1'b1, 1'b0, 16'h0003, 32'h0000_0040, 32'h0000_0000, 3'd1, 8'd9},  // R9 RPL 3
        '{1'b1, 1'b0, 16'h0004, 32'h0000_0000, 32'h0000_0000, 3'd2, 8'd10}, // R10, R13 order
        '{1'b1, 1'b0, 16'h000C, 32'h0000_0000, 32'h0000_0000, 3'd2, 8'd10}, // R10
        '{1'b1, 1'b0, 16'h0018, 32'h0000_0000, 32'h0000_0000, 3'd3, 8'd11}  // R11 size
    };

    task automatic do_wr(input logic [1:0] k, input logic [31:0] a, input logic [63:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = k; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_kind = 2'd3;
    endtask

    task automatic check_out(input logic [31:0] exp_lin, input logic [2:0] exp_cause,
                             input string tag);
        checks++;
        if (lin_addr !== exp_lin || fault_cause !== exp_cause ||
            fault !== (exp_cause != 3'd0)) begin
            errors++;
            $display("FAIL %s: lin=%h cause=%0d fault=%b expected lin=%h cause=%0d",
                     tag, lin_addr, fault_cause, fault, exp_lin, exp_cause);
        end
    endtask

    task automatic xlat(input logic [15:0] s, input logic [31:0] o,
                        input logic [31:0] exp_lin, input logic [2:0] exp_cause,
                        input string tag);
        @(negedge clk);
        seg_in = s; off_in = o;
        @(posedge clk);
        #1;
        check_out(exp_lin, exp_cause, tag);
    endtask

    function automatic logic [63:0] tbl_word(input logic [31:0] base, input logic [15:0] size);
        return {16'h0000, base, size};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check_out(32'h000F_FFF0, 3'd0, "R1 reset address");
        xlat(16'h0000, 32'h0000_1234, 32'h0000_1234, 3'd0, "R1 protected mode off");
        xlat(16'hFFFF, 32'h0000_0010, 32'h0000_0000, 3'd0, "R1 A20 closed");

        do_wr(2'd1, 32'h0, tbl_word(32'h0000_1000, 16'h0017));
        do_wr(2'd2, 32'h0000_1000, 64'hFFFF_FFFF_FFFF_FFFF);
        do_wr(2'd2, 32'h0000_1008, 64'h00CF_9A00_0000_FFFF);
        do_wr(2'd2, 32'h0000_1013, 64'h1240_9234_5678_0FFF);
        do_wr(2'd2, 32'h0000_1018, 64'hAB41_92CD_0000_2345);

        for (int i = 0; i < 16; i++) begin
            do_wr(2'd0, 32'h0, {62'b0, VECS[i].a20, VECS[i].pe});
            xlat(VECS[i].seg, VECS[i].off, VECS[i].lin, VECS[i].cause,
                 $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R11 / R12: widened table, non-granular limit from two limit fields
        do_wr(2'd0, 32'h0, 64'h1);
        do_wr(2'd1, 32'h0, tbl_word(32'h0000_1000, 16'h001F));
        xlat(16'h0018, 32'h0001_2345, 32'hABCE_2345, 3'd0, "R11 index admitted, R12 limit equal");
        xlat(16'h0018, 32'h0001_2346, 32'h0000_0000, 3'd4, "R12 limit exceeded");

        // R5: write below the base wraps to a large slot and must be ignored
        do_wr(2'd2, 32'h0000_0FF8, 64'h0);
        xlat(16'h0018, 32'h0000_0000, 32'hABCD_0000, 3'd0, "R5 out-of-range write ignored");

        // R4: kind 3 writes nothing
        do_wr(2'd3, 32'h0000_1008, 64'h0);
        xlat(16'h0008, 32'h0000_0020, 32'h0000_0020, 3'd0, "R4 kind 3 no effect");

        // R5: relocated base
        do_wr(2'd1, 32'h0, tbl_word(32'h0000_2000, 16'h001F));
        do_wr(2'd2, 32'h0000_2008, 64'h0040_9200_4000_00FF);
        xlat(16'h0008, 32'h0000_0010, 32'h0000_4010, 3'd0, "R5 relocated base");
        xlat(16'h0008, 32'h0000_0100, 32'h0000_0000, 3'd4, "R12 small limit");

        // R11: size admits index 4 but storage does not
        do_wr(2'd1, 32'h0, tbl_word(32'h0000_2000, 16'h0027));
        xlat(16'h0020, 32'h0000_0000, 32'h0000_0000, 3'd3, "R11 beyond storage");

        // R4: back to real mode
        do_wr(2'd0, 32'h0, 64'h0);
        xlat(16'h0008, 32'h0000_0000, 32'h0000_0080, 3'd0, "R4 real mode restored");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule